// File: doc/BRIEF.md
# Lane-Parallel Counter-Mode Keystream Combiner

This block runs counter-mode encryption across several independent cipher lanes at once. A single base counter is held in a register. When a group of plaintext blocks arrives with a start strobe, the block forms one counter value per lane by adding that lane's own fixed increment to the base. It offers the whole group of counter values to an external cipher datapath through a valid/ready handshake. Only counter values ever reach the cipher. Plaintext never does.

When the cipher returns one encrypted block per lane, each lane's ciphertext is formed as its stored plaintext XOR the keystream for that lane. The ciphertext group is then shown for one cycle with a valid flag. No lane depends on another lane or on any earlier ciphertext, so every lane is computed in the same cycle. Decryption uses exactly the same path: ciphertext fed back under the same counters gives back the plaintext.

Only one group can be in flight at a time. After each group is issued, the base counter moves forward by the lane count, so counter values never repeat between groups. The counter wraps modulo 2^BLK_W.

Top module: `lane_ctr_xor`

## Requirements
- R1: After synchronous active-high reset, `busy_o`, `ctr_valid_o` and `ct_valid_o` are 0 and the base counter is 0, so the first group's lane 0 counter is 1.
- R2: While `ctr_valid_o` is 1, lane k of `ctr_o` (bits [k*BLK_W +: BLK_W], lane 0 lowest) equals base + k + 1 modulo 2^BLK_W.
- R3: `ctr_valid_o` rises in the cycle after a start is accepted. It stays at 1, with `ctr_o` unchanged, until a cycle in which `ctr_ready_i` is 1, and then it drops.
- R4: Each completed counter handshake advances the base by LANES modulo 2^BLK_W, so the next group continues from where the last one ended, including across wrap.
- R5: In the cycle after `ks_valid_i` is accepted, `ct_valid_o` is 1 for exactly one cycle, and lane k of `ct_o` equals lane k of the plaintext registered at start XOR lane k of `ks_i`.
- R6: Plaintext is captured on the accepted start. Later changes on `pt_i` do not affect the resulting ciphertext.
- R7: `start_i` is accepted only while `busy_o` is 0. `busy_o` is 1 from the cycle after an accepted start until the cycle after keystream is accepted. `ks_valid_i` is accepted only after the counter handshake has completed and before the keystream has returned; at any other time it has no effect on `ct_valid_o`.
- R8: `ctr_load_i` sets the base to `ctr_seed_i` only while `busy_o` is 0. A load in the same cycle as a start applies to that group. A load while busy is ignored.
- R9: Feeding a ciphertext group back in as plaintext under the same counters, with the same cipher, returns the original plaintext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctr_load_i | input | 1 | Load base counter from seed (idle only) |
| ctr_seed_i | input | BLK_W | New base counter value |
| start_i | input | 1 | Start strobe for a plaintext group |
| pt_i | input | LANES*BLK_W | Plaintext group, lane 0 in low bits |
| busy_o | output | 1 | A group is in flight |
| ctr_valid_o | output | 1 | Counter group offered to the cipher |
| ctr_ready_i | input | 1 | Cipher accepts the counter group |
| ctr_o | output | LANES*BLK_W | Counter values, one per lane |
| ks_valid_i | input | 1 | Cipher returns the keystream group |
| ks_i | input | LANES*BLK_W | Encrypted counters, one per lane |
| ct_valid_o | output | 1 | Ciphertext group valid (one cycle) |
| ct_o | output | LANES*BLK_W | Ciphertext group |

## Verification
On every cycle, the assertions check four things: that adjacent lane counters differ by exactly one, that the offered counter group holds steady under backpressure, that at most one group is in flight, and that the ciphertext valid flag is a single-cycle pulse. Only the bench scenarios can show the rest. These are the absolute counter values after seeding and wrap, the lane-count step of the base between groups, and the XOR result against a substitute cipher. They also cover the values that are ignored: pokes at plaintext, start, seed load and keystream while a group is in flight. Another scenario reloads a seed and returns the original plaintext from its own ciphertext.

// File: rtl/lane_ctr_pkg.sv
package lane_ctr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } ctr_state_e;
endpackage

// File: rtl/lane_ctr_fsm.sv
module lane_ctr_fsm
  import lane_ctr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       ctr_ready_i,
  input  logic       ks_valid_i,
  output ctr_state_e state_o,
  output logic       start_take_o,
  output logic       issue_fire_o,
  output logic       ks_take_o
);
  ctr_state_e state_q, state_d;

  assign start_take_o = (state_q == ST_IDLE)  && start_i;
  assign issue_fire_o = (state_q == ST_ISSUE) && ctr_ready_i;
  assign ks_take_o    = (state_q == ST_WAIT)  && ks_valid_i;
  assign state_o      = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i)     state_d = ST_ISSUE;
      ST_ISSUE: if (ctr_ready_i) state_d = ST_WAIT;
      ST_WAIT:  if (ks_valid_i)  state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  // R7: an issue phase is only ever entered from idle
  assert_issue_entry_R7: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_ISSUE) && !$past(state_q == ST_ISSUE)) |-> $past(state_q == ST_IDLE));

  // R7: keystream return only follows a completed counter handshake
  assert_wait_entry_R7: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_WAIT) && !$past(state_q == ST_WAIT)) |-> $past(state_q == ST_ISSUE));
endmodule

// File: rtl/lane_ctr_base.sv
module lane_ctr_base #(
  parameter int BLK_W = 128,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [BLK_W-1:0] seed_i,
  input  logic             advance_i,
  output logic [BLK_W-1:0] base_o
);
  localparam logic [BLK_W-1:0] STEP = BLK_W'(LANES);

  function automatic logic [BLK_W-1:0] next_base(input logic [BLK_W-1:0] b);
    return b + STEP;
  endfunction

  logic [BLK_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst)            base_q <= '0;
    else if (load_i)    base_q <= seed_i;
    else if (advance_i) base_q <= next_base(base_q);
  end

  assign base_o = base_q;

  // R8: load (idle only) and advance (issue only) never coincide
  assert_load_adv_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(load_i && advance_i));

  // R4: with neither load nor advance, the base is untouched
  assert_base_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !advance_i) |=> $stable(base_q));
endmodule

// File: rtl/lane_ctr_gen.sv
module lane_ctr_gen #(
  parameter int BLK_W = 128,
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [BLK_W-1:0]       base_i,
  output logic [LANES*BLK_W-1:0] ctr_o
);
  function automatic logic [BLK_W-1:0] lane_value(input logic [BLK_W-1:0] b, input int k);
    return b + BLK_W'(k + 1);
  endfunction

  logic [BLK_W-1:0] lane_w [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_w[k] = lane_value(base_i, k);
    assign ctr_o[k*BLK_W +: BLK_W] = lane_w[k];
    if (k > 0) begin : g_step
      // R2: neighbouring lanes are one apart, modulo 2^BLK_W
      assert_lane_step_R2: assert property (@(posedge clk) disable iff (rst)
        (lane_w[k] - lane_w[k-1]) == BLK_W'(1));
    end
  end
endmodule

// File: rtl/lane_xor_combine.sv
module lane_xor_combine #(
  parameter int BLK_W = 128,
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_take_i,
  input  logic [LANES*BLK_W-1:0] pt_i,
  input  logic                   ks_take_i,
  input  logic [LANES*BLK_W-1:0] ks_i,
  output logic                   ct_valid_o,
  output logic [LANES*BLK_W-1:0] ct_o
);
  localparam int GW = LANES * BLK_W;

  logic [GW-1:0] pt_q, ct_q, ct_d;
  logic          ctv_q;

  for (genvar k = 0; k < LANES; k++) begin : g_xor
    assign ct_d[k*BLK_W +: BLK_W] = pt_q[k*BLK_W +: BLK_W] ^ ks_i[k*BLK_W +: BLK_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pt_q  <= '0;
      ct_q  <= '0;
      ctv_q <= 1'b0;
    end else begin
      if (start_take_i) pt_q <= pt_i;
      if (ks_take_i)    ct_q <= ct_d;
      ctv_q <= ks_take_i;
    end
  end

  assign ct_valid_o = ctv_q;
  assign ct_o       = ct_q;

  // R7: capture and return are never in the same cycle
  assert_take_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(start_take_i && ks_take_i));

  // R5: ciphertext valid is a single-cycle pulse
  assert_ct_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    ctv_q |=> !ctv_q);

  // R6: plaintext is held while a group is in flight
  assert_pt_hold_R6: assert property (@(posedge clk) disable iff (rst)
    ks_take_i |-> $stable(pt_q));
endmodule

// File: rtl/lane_ctr_xor.sv
module lane_ctr_xor
  import lane_ctr_pkg::*;
#(
  parameter int BLK_W = 128,
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ctr_load_i,
  input  logic [BLK_W-1:0]       ctr_seed_i,
  input  logic                   start_i,
  input  logic [LANES*BLK_W-1:0] pt_i,
  output logic                   busy_o,
  output logic                   ctr_valid_o,
  input  logic                   ctr_ready_i,
  output logic [LANES*BLK_W-1:0] ctr_o,
  input  logic                   ks_valid_i,
  input  logic [LANES*BLK_W-1:0] ks_i,
  output logic                   ct_valid_o,
  output logic [LANES*BLK_W-1:0] ct_o
);
  ctr_state_e       state_w;
  logic             start_take_w, issue_fire_w, ks_take_w, load_ok_w;
  logic [BLK_W-1:0] base_w;

  lane_ctr_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .ctr_ready_i  (ctr_ready_i),
    .ks_valid_i   (ks_valid_i),
    .state_o      (state_w),
    .start_take_o (start_take_w),
    .issue_fire_o (issue_fire_w),
    .ks_take_o    (ks_take_w)
  );

  assign load_ok_w   = ctr_load_i && (state_w == ST_IDLE);
  assign busy_o      = (state_w != ST_IDLE);
  assign ctr_valid_o = (state_w == ST_ISSUE);

  lane_ctr_base #(.BLK_W(BLK_W), .LANES(LANES)) u_base (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load_ok_w),
    .seed_i    (ctr_seed_i),
    .advance_i (issue_fire_w),
    .base_o    (base_w)
  );

  lane_ctr_gen #(.BLK_W(BLK_W), .LANES(LANES)) u_gen (
    .clk    (clk),
    .rst    (rst),
    .base_i (base_w),
    .ctr_o  (ctr_o)
  );

  lane_xor_combine #(.BLK_W(BLK_W), .LANES(LANES)) u_xor (
    .clk          (clk),
    .rst          (rst),
    .start_take_i (start_take_w),
    .pt_i         (pt_i),
    .ks_take_i    (ks_take_w),
    .ks_i         (ks_i),
    .ct_valid_o   (ct_valid_o),
    .ct_o         (ct_o)
  );

  // R3: an offered counter group holds until accepted
  assert_ctr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (ctr_valid_o && !ctr_ready_i) |=> (ctr_valid_o && $stable(ctr_o)));

  // R3: an accepted group is withdrawn on the next cycle
  assert_ctr_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (ctr_valid_o && ctr_ready_i) |=> !ctr_valid_o);

  // R5: ciphertext never appears while counters are still offered
  assert_ct_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    ctr_valid_o |-> !ct_valid_o);
endmodule

// File: tb/tb_lane_ctr_xor.sv
module tb_lane_ctr_xor;
  localparam int W  = 128;
  localparam int L  = 4;
  localparam int GW = W * L;
  localparam logic [W-1:0] KEY = 128'h5a17_c3e9_0b44_d2f1_9e6a_2c85_71bd_e036;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ctr_load = 1'b0;
  logic [W-1:0]  seed = '0;
  logic          start = 1'b0;
  logic [GW-1:0] pt = '0;
  logic          busy, ctr_valid, ct_valid;
  logic          ctr_ready = 1'b0;
  logic [GW-1:0] ctr, ct;
  logic          ks_valid = 1'b0;
  logic [GW-1:0] ks = '0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [W-1:0] exp_base;

  always #2.5 clk = ~clk;

  lane_ctr_xor #(.BLK_W(W), .LANES(L)) dut (
    .clk(clk), .rst(rst), .ctr_load_i(ctr_load), .ctr_seed_i(seed),
    .start_i(start), .pt_i(pt), .busy_o(busy), .ctr_valid_o(ctr_valid),
    .ctr_ready_i(ctr_ready), .ctr_o(ctr), .ks_valid_i(ks_valid), .ks_i(ks),
    .ct_valid_o(ct_valid), .ct_o(ct)
  );

  function automatic logic [W-1:0] cipher(input logic [W-1:0] x);
    return {x[W-6:0], x[W-1:W-5]} ^ KEY;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [GW-1:0] act, input logic [GW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic load_seed(input logic [W-1:0] v);
    @(negedge clk); ctr_load = 1'b1; seed = v;
    @(negedge clk); ctr_load = 1'b0;
    exp_base = v;
  endtask

  // Runs one group; poke = disturb inputs while busy (R6, R7, R8)
  task automatic run_group(input logic [GW-1:0] ptv, input int rdly, input int kdly,
                           input bit poke, output logic [GW-1:0] ctv);
    logic [GW-1:0] saved, ksv;
    @(negedge clk); start = 1'b1; pt = ptv;
    @(negedge clk); start = 1'b0;
    chk(ctr_valid == 1'b1, "R3 valid after start", GW'(ctr_valid), GW'(1));
    chk(busy == 1'b1, "R7 busy after start", GW'(busy), GW'(1));
    for (int k = 0; k < L; k++)
      chk(ctr[k*W +: W] == exp_base + W'(k + 1), "R2 lane counter",
          GW'(ctr[k*W +: W]), GW'(exp_base + W'(k + 1)));
    saved = ctr;
    for (int i = 0; i < rdly; i++) begin
      if (poke) begin
        pt = ~ptv; start = 1'b1; ctr_load = 1'b1; seed = 128'hdead_beef; ks_valid = 1'b1;
      end
      @(negedge clk);
      start = 1'b0; ctr_load = 1'b0; ks_valid = 1'b0;
      chk(ctr_valid && ctr == saved, "R3 hold under backpressure", ctr, saved);
      chk(!ct_valid, "R7 keystream ignored during issue", GW'(ct_valid), GW'(0));
    end
    ctr_ready = 1'b1;
    @(negedge clk); ctr_ready = 1'b0;
    exp_base = exp_base + W'(L);
    chk(!ctr_valid, "R3 drop after handshake", GW'(ctr_valid), GW'(0));
    for (int i = 0; i < kdly; i++) begin
      if (poke) begin start = 1'b1; ctr_load = 1'b1; end
      @(negedge clk);
      start = 1'b0; ctr_load = 1'b0;
      chk(!ct_valid && busy, "R5 no output before keystream", GW'(ct_valid), GW'(0));
    end
    for (int k = 0; k < L; k++) ksv[k*W +: W] = cipher(saved[k*W +: W]);
    ks_valid = 1'b1; ks = ksv;
    @(negedge clk); ks_valid = 1'b0;
    chk(ct_valid == 1'b1, "R5 valid after keystream", GW'(ct_valid), GW'(1));
    chk(ct == (ptv ^ ksv), "R5 R6 ciphertext", ct, ptv ^ ksv);
    chk(!busy, "R7 idle after return", GW'(busy), GW'(0));
    ctv = ct;
    @(negedge clk);
    chk(!ct_valid, "R5 single-cycle pulse", GW'(ct_valid), GW'(0));
  endtask

  initial begin
    logic [GW-1:0] c0, c1, c2, pA, pB;
    pA = {128'h0123_4567_89ab_cdef_0011_2233_4455_6677, 128'hffee_ddcc_bbaa_9988_7766_5544_3322_1100,
          128'h1357_9bdf_2468_ace0_f0e1_d2c3_b4a5_9687, 128'h0000_0000_0000_0000_0000_0000_0000_0001};
    pB = ~pA ^ {L{128'h3c3c_a5a5_0f0f_9696_c3c3_5a5a_f0f0_6969}};
    exp_base = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !ctr_valid && !ct_valid, "R1 flags low after reset",
        GW'({busy, ctr_valid, ct_valid}), GW'(0));
    // R1 R2: first group uses base 0
    run_group(pA, 0, 0, 1'b0, c0);
    // R4: second group continues from base 4, with backpressure and delay
    run_group(pB, 3, 2, 1'b0, c1);
    // R7: stray keystream while idle
    @(negedge clk); ks_valid = 1'b1;
    @(negedge clk); ks_valid = 1'b0;
    chk(!ct_valid, "R7 keystream ignored while idle", GW'(ct_valid), GW'(0));
    // R6 R7 R8: pokes while busy are ignored
    run_group(pA, 2, 2, 1'b1, c2);
    // R8: load ignored while busy, so base is still exp_base here
    run_group(pB, 1, 0, 1'b0, c2);
    // R4: wrap across 2^W
    load_seed({W{1'b1}} - W'(1));
    run_group(pA, 0, 1, 1'b0, c2);
    chk(exp_base == W'(2), "R4 base wrapped", GW'(exp_base), GW'(2));
    run_group(pB, 0, 0, 1'b0, c2);
    // R8: load together with start applies to that group
    @(negedge clk); start = 1'b1; ctr_load = 1'b1; seed = 128'h1000; pt = pA;
    @(negedge clk); start = 1'b0; ctr_load = 1'b0;
    chk(ctr[W-1:0] == W'(128'h1001), "R8 load with start", GW'(ctr[W-1:0]), GW'(128'h1001));
    ctr_ready = 1'b1;
    @(negedge clk); ctr_ready = 1'b0;
    ks_valid = 1'b1;
    @(negedge clk); ks_valid = 1'b0;
    exp_base = W'(128'h1004);
    @(negedge clk);
    // R9: decrypt c0 under the first group's counters
    load_seed('0);
    run_group(c0, 1, 1, 1'b0, c2);
    chk(c2 == pA, "R9 decrypt restores plaintext", c2, pA);
    load_seed(W'(4));
    run_group(c1, 0, 0, 1'b0, c2);
    chk(c2 == pB, "R9 decrypt second group", c2, pB);
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule